// File: doc/BRIEF.md
# Ordered Dial Combination Lock

This block is a small synchronous state machine that behaves like a mechanical dial lock. The lock opens only when it receives one fixed series of three dial operations in the right order. Each operation consists of a turn direction and a dial number. A one-cycle valid strobe marks each operation, so the machine advances only when an operation arrives. It never advances because clock cycles have passed.

The machine has four progress levels:

- **Idle:** the lock is closed and no useful step has been taken.
- **One step:** the first correct step is done.
- **Two steps:** the first two correct steps are done.
- **Open:** the lock is open.

Two state bits hold these levels. The code is a right turn to 13, then a left turn to 22, then a right turn to 3. Any operation that does not match the next expected step sends the machine back to idle. Once open, the lock stays open and ignores dial operations until the relock input is pulsed.

Top module: `dial_lock`

## Requirements
- R1: A synchronous active-high reset `rst` puts the machine in the idle state, with `unlocked` low on the first clock edge at which `rst` is high.
- R2: An operation is taken only on a rising clock edge where `op_valid` is 1. On edges where `op_valid` is 0 and `relock` is 0, the progress state and `unlocked` hold their values.
- R3: The direction encoding is `op_right` = 1 for a right turn and 0 for a left turn. `op_pos` is the 5-bit dial number. The code is right-13, then left-22, then right-3.
- R4: `unlocked` rises one clock edge after the third correct operation is accepted, and only when the three correct operations arrived in order with no other valid operation between them.
- R5: From idle, one step or two steps, any valid operation that differs from the next expected one, in direction or number, returns the machine to idle. This includes a repeat of an earlier correct step.
- R6: While open, valid operations of any value are ignored, and `unlocked` stays 1.
- R7: `relock` = 1 on a clock edge returns the machine to idle from any state. It takes priority over a valid operation on the same edge.
- R8: `unlocked` is 1 only in the open state and is driven straight from the state register, with no dependence on the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe that qualifies a dial operation |
| op_right | input | 1 | Turn direction: 1 = right, 0 = left |
| op_pos | input | 5 | Dial number of the operation |
| relock | input | 1 | Returns the lock to the closed idle state |
| unlocked | output | 1 | High while the lock is open |

## Verification
The bench aims at the following ordering traps:

- **A repeat of the first step while one step is done.** A design that kept its progress on a repeated first step would open on right-13, right-13, left-22, right-3.
- **A correct number with the wrong direction, or the right direction with a neighbouring number.** These catch a matcher that compares only one of the two fields.
- **Wrong or correct operations presented while open.** A design that went on matching in the open state would relock itself.
- **Relock on the same edge as a valid operation, and relock in the middle of a sequence.** These expose a design that gives operations priority, or that clears only the open state.

Idle cycles between operations must leave progress alone. A design that stepped on the clock instead of on the strobe would fail there.

// File: rtl/dial_lock_pkg.sv
package dial_lock_pkg;

    localparam int POS_W   = 5;
    localparam int STEPS   = 3;
    localparam int STATE_W = $clog2(STEPS + 1);

    localparam logic             STEP0_RIGHT = 1'b1;
    localparam logic [POS_W-1:0] STEP0_POS   = POS_W'(13);
    localparam logic             STEP1_RIGHT = 1'b0;
    localparam logic [POS_W-1:0] STEP1_POS   = POS_W'(22);
    localparam logic             STEP2_RIGHT = 1'b1;
    localparam logic [POS_W-1:0] STEP2_POS   = POS_W'(3);

    typedef enum logic [STATE_W-1:0] {
        LK_IDLE  = 2'd0,
        LK_ONE   = 2'd1,
        LK_TWO   = 2'd2,
        LK_OPEN  = 2'd3
    } lock_state_t;

    typedef struct packed {
        logic             right;
        logic [POS_W-1:0] pos;
    } dial_op_t;

    function automatic dial_op_t expected_op(input lock_state_t st);
        dial_op_t r;
        case (st)
            LK_IDLE: begin r.right = STEP0_RIGHT; r.pos = STEP0_POS; end
            LK_ONE:  begin r.right = STEP1_RIGHT; r.pos = STEP1_POS; end
            LK_TWO:  begin r.right = STEP2_RIGHT; r.pos = STEP2_POS; end
            default: begin r.right = 1'b0;        r.pos = '0;        end
        endcase
        return r;
    endfunction

    function automatic lock_state_t advance(input lock_state_t st);
        return lock_state_t'(st + 1'b1);
    endfunction

endpackage

// File: rtl/dial_step_match.sv
module dial_step_match
    import dial_lock_pkg::*;
(
    input  lock_state_t state,
    input  dial_op_t    op,
    output logic        hit
);
    dial_op_t want;

    always_comb begin
        want = expected_op(state);
        // R3: both direction and number must agree
        hit  = (state != LK_OPEN) && (op.right == want.right) && (op.pos == want.pos);
    end
endmodule

// File: rtl/dial_lock_next.sv
module dial_lock_next
    import dial_lock_pkg::*;
(
    input  lock_state_t state,
    input  logic        op_valid,
    input  logic        hit,
    input  logic        relock,
    output lock_state_t state_nx
);
    always_comb begin
        state_nx = state;
        if (relock) begin
            state_nx = LK_IDLE;                  // R7
        end else if (op_valid) begin
            if (state == LK_OPEN)
                state_nx = LK_OPEN;              // R6
            else if (hit)
                state_nx = advance(state);       // R4
            else
                state_nx = LK_IDLE;              // R5
        end
    end
endmodule

// File: rtl/dial_lock_state_reg.sv
module dial_lock_state_reg
    import dial_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lock_state_t state_nx,
    output lock_state_t state
);
    always_ff @(posedge clk) begin
        if (rst) state <= LK_IDLE;               // R1
        else     state <= state_nx;
    end
endmodule

// File: rtl/dial_lock.sv
module dial_lock
    import dial_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic             op_right,
    input  logic [POS_W-1:0] op_pos,
    input  logic             relock,
    output logic             unlocked
);
    lock_state_t state;
    lock_state_t state_nx;
    dial_op_t    op;
    logic        hit;

    assign op.right = op_right;
    assign op.pos   = op_pos;

    dial_step_match u_match (
        .state (state),
        .op    (op),
        .hit   (hit)
    );

    dial_lock_next u_next (
        .state    (state),
        .op_valid (op_valid),
        .hit      (hit),
        .relock   (relock),
        .state_nx (state_nx)
    );

    dial_lock_state_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .state_nx (state_nx),
        .state    (state)
    );

    // R8: the open output decodes the register only
    assign unlocked = (state == LK_OPEN);
endmodule

// File: rtl/dial_lock_chk.sv
module dial_lock_chk
    import dial_lock_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             op_right,
    input logic [POS_W-1:0] op_pos,
    input logic             relock,
    input logic             unlocked,
    input lock_state_t      state
);
    // R1: reset closes the lock
    a_r1_reset_closed: assert property (@(posedge clk) rst |=> !unlocked);

    // R2: no strobe and no relock leaves progress untouched
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !relock) |=> $stable(state));

    // R4: opening requires the final right-3 step on the prior edge
    a_r4_open_on_last: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(op_valid && op_right && op_pos == STEP2_POS && !relock));

    // R6: open stays open without relock
    a_r6_open_sticky: assert property (@(posedge clk) disable iff (rst)
        (unlocked && !relock) |=> unlocked);

    // R7: relock always closes
    a_r7_relock_closes: assert property (@(posedge clk) disable iff (rst)
        relock |=> (state == LK_IDLE));

    // R8: the output matches the open state
    a_r8_out_state: assert property (@(posedge clk) disable iff (rst)
        unlocked == (state == LK_OPEN));
endmodule

bind dial_lock dial_lock_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_right (op_right),
    .op_pos   (op_pos),
    .relock   (relock),
    .unlocked (unlocked),
    .state    (state)
);

// File: tb/dial_lock_bench.sv
module dial_lock_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic       op_right = 1'b0;
    logic [4:0] op_pos = 5'd0;
    logic       relock = 1'b0;
    logic       unlocked;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int model_prog = 0;            // 0..2 steps done, 3 = open
    string cur_req = "R1";
    bit    done = 1'b0;

    int exp_right [3] = '{1, 0, 1};   // R3 code
    int exp_pos   [3] = '{13, 22, 3};

    always #2.5 clk = ~clk;           // 200 MHz

    dial_lock u_dial_lock (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_right (op_right),
        .op_pos   (op_pos),
        .relock   (relock),
        .unlocked (unlocked)
    );

    // reference model, compared on every clock
    always @(posedge clk) begin
        if (rst) model_prog = 0;
        else if (relock) model_prog = 0;
        else if (op_valid) begin
            if (model_prog == 3) model_prog = 3;
            else if (int'(op_right) == exp_right[model_prog] && int'(op_pos) == exp_pos[model_prog])
                model_prog = model_prog + 1;
            else model_prog = 0;
        end
        #1;
        compared++;
        if (unlocked !== (model_prog == 3)) begin
            mismatched++;
            $display("FAIL %s cycle %0d: unlocked=%b expected=%b", cur_req, cycles,
                     unlocked, (model_prog == 3));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic dial(input logic r, input int p);
        @(negedge clk);
        op_valid = 1'b1; op_right = r; op_pos = 5'(p);
        @(negedge clk);
        op_valid = 1'b0; op_right = 1'b0; op_pos = 5'd0;
    endtask

    task automatic do_relock();
        @(negedge clk); relock = 1'b1;
        @(negedge clk); relock = 1'b0;
    endtask

    task automatic expect_open(input logic v, input string req);
        compared++;
        if (unlocked !== v) begin
            mismatched++;
            $display("FAIL %s: unlocked=%b expected=%b", req, unlocked, v);
        end
    endtask

    initial begin
        cur_req = "R1";
        idle(3);
        expect_open(1'b0, "R1");
        rst = 1'b0;
        idle(2);

        cur_req = "R4";                       // correct order with gaps (R2)
        dial(1, 13); idle(3);
        cur_req = "R2";
        dial(0, 22); idle(5);
        cur_req = "R4";
        dial(1, 3);
        expect_open(1'b1, "R4");

        cur_req = "R6";                       // ops while open
        dial(0, 5); dial(1, 13); dial(1, 3);
        expect_open(1'b1, "R6");

        cur_req = "R7";
        do_relock();
        expect_open(1'b0, "R7");

        cur_req = "R5";                       // wrong direction on first step
        dial(0, 13); dial(0, 22); dial(1, 3);
        expect_open(1'b0, "R5");

        dial(1, 13); dial(0, 22); dial(0, 3); // wrong direction last step
        dial(0, 22); dial(1, 3);
        expect_open(1'b0, "R5");

        dial(1, 13); dial(1, 13); dial(0, 22); dial(1, 3); // repeated first step
        expect_open(1'b0, "R5");

        cur_req = "R3";
        dial(1, 13); dial(0, 22); dial(1, 4); // neighbouring number
        expect_open(1'b0, "R3");
        dial(1, 13); dial(0, 21); dial(1, 3);
        expect_open(1'b0, "R3");

        cur_req = "R7";                       // relock mid-sequence
        dial(1, 13); dial(0, 22); do_relock(); dial(1, 3);
        expect_open(1'b0, "R7");

        cur_req = "R8";                       // open again, output from state only
        dial(1, 13); dial(0, 22); dial(1, 3);
        expect_open(1'b1, "R8");
        @(negedge clk); op_valid = 1'b1; op_right = 1'b0; op_pos = 5'd9;
        #1 expect_open(1'b1, "R8");

        cur_req = "R7";                       // relock together with a valid op
        relock = 1'b1; op_right = 1'b1; op_pos = 5'd13;
        @(negedge clk); relock = 1'b0; op_valid = 1'b0; op_pos = 5'd0; op_right = 1'b0;
        expect_open(1'b0, "R7");
        dial(0, 22); dial(1, 3);
        expect_open(1'b0, "R7");

        cur_req = "R1";                       // reset while open
        dial(1, 13); dial(0, 22); dial(1, 3);
        expect_open(1'b1, "R4");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        expect_open(1'b0, "R1");
        idle(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule